// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable model of a small pipelined synchronous static RAM with burst access. A bus master opens an access by pulling one of two address strobes low while the three chip selects are in their active state. The block then registers the address. The lowest two address bits seed a 2-bit burst counter, and an advance input steps that counter on later clocks. Writes are qualified per 9-bit byte lane, or forced onto every lane by a global write enable. Reads are registered, so data reaches the output one clock after the cycle that carries its address.

The tri-state data bus is split into `din`, `dout` and a drive enable `dout_en`. The enable follows the asynchronous output-enable input `oe_n`. For the first data clock of a read that opens from a deselected state, the enable is held off whatever `oe_n` is. Every other input is sampled on the rising clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: An access opens when a recognised strobe is low and `sel1_n`=0, `sel2`=1, `sel3_n`=0. A read opened in cycle N shows `mem[addr]` on `dout` with `dout_en`=1 after the edge that ends cycle N, unless R10 applies.
- R2: A recognised strobe that samples any chip select inactive deselects the block. `dout_en` is 0 from the next clock, and that cycle writes nothing.
- R3: When both strobes are low, the processor strobe `ads_cpu_n` wins. An access it opens is always a read, and the write enables are ignored in that cycle.
- R4: While `sel1_n`=1, `ads_cpu_n` is ignored completely. An ongoing burst continues as if no strobe were present. `ads_ctl_n` is not gated by `sel1_n`.
- R5: On a cycle of an open burst with no strobe and `adv_n`=0, the address low two bits step by +1 modulo 4 (linear order, wrapping). The upper address bits stay fixed.
- R6: On a cycle of an open burst with no strobe and `adv_n`=1, the address is held and read again. No write takes place.
- R7: `wr_all_n`=0 writes all four lanes, whatever `wr_byte_n` and `lane_n` are.
- R8: With `wr_all_n`=1, lane i (bits [9i+8:9i]) is written only when `wr_byte_n`=0 and `lane_n[i]`=0. With `wr_byte_n`=1 the cycle is a read.
- R9: `oe_n`=1 forces `dout_en` to 0 at once, without a clock. `oe_n`=0 lets a pending read drive.
- R10: The first data clock of a read opened from the deselected state keeps `dout_en`=0 even when `oe_n`=0.
- R11: Write data is taken in the opening cycle of a write and in each advancing cycle that follows it. `dout_en` is 0 on the clock after a write.
- R12: After reset the block is deselected and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| ads_cpu_n | input | 1 | Processor address strobe, active low, gated by sel1_n |
| ads_ctl_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
Read data and its drive enable are due one edge after the cycle that carries the address. The bench sets the inputs 1 ns after an edge, lets exactly one edge pass, and samples 1 ns later, so each check looks at the result of the cycle just issued. Deselect and write cycles take effect at that same next edge. An `oe_n` change is checked 1 ns after it is applied, with no edge in between. Stored contents are observed only through later reads.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    ads_cpu_n,
  input  logic                    ads_ctl_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    cur_a, eff_a;
  logic [DW-1:0]    rd_q;
  logic [LANES-1:0] wmask;
  logic active, rd_v, first_q;
  logic en_ok, cpu_hit, strobe, go, desel, adv_go, hold, do_wr, do_rd;

  assign en_ok   = !sel1_n && sel2 && !sel3_n;
  assign cpu_hit = !ads_cpu_n && !sel1_n;
  assign strobe  = cpu_hit || !ads_ctl_n;
  assign go      = strobe && en_ok;
  assign desel   = strobe && !en_ok;
  assign adv_go  = !strobe && active && !adv_n;
  assign hold    = !strobe && active && adv_n;

  assign eff_a = go ? addr :
                 adv_go ? {cur_a[AW-1:2], cur_a[1:0] + 2'd1} : cur_a;

  assign wmask = !wr_all_n ? {LANES{1'b1}} :
                 (!wr_byte_n ? ~lane_n : {LANES{1'b0}});
  assign do_wr = ((go && !cpu_hit) || adv_go) && (|wmask);
  assign do_rd = (go || adv_go || hold) && !do_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_v    <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (go)         active <= 1'b1;
      else if (desel) active <= 1'b0;
      rd_v    <= do_rd;
      first_q <= do_rd && go && !active;
    end
  end

  always_ff @(posedge clk) begin
    if (go || adv_go) cur_a <= eff_a;
    if (do_rd) rd_q <= mem[eff_a];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (do_wr && wmask[i])
        mem[eff_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    end
  end

  assign dout    = rd_q;
  assign dout_en = rd_v && !oe_n && !first_q;

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !dout_en); // R2
  AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit && en_ok) |=> rd_v); // R3
  AST_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    adv_go |=> $stable(cur_a[AW-1:2])); // R5
  AST_FIRST_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !active && !do_wr) |=> !dout_en); // R10
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> !dout_en); // R11
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !dout_en); // R12
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = '0;
  logic        ads_cpu_n = 1, ads_ctl_n = 1;
  logic        sel1_n = 0, sel2 = 1, sel3_n = 0;
  logic        adv_n = 1, wr_all_n = 1, wr_byte_n = 1;
  logic [3:0]  lane_n = 4'hF;
  logic        oe_n = 0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_en;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_cpu_n(ads_cpu_n),
    .ads_ctl_n(ads_ctl_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    ads_cpu_n = 1; ads_ctl_n = 1; sel1_n = 0; sel2 = 1; sel3_n = 0;
    adv_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; oe_n = 0;
  endtask

  task automatic open_ctl(input logic [7:0] a, input logic gw, input logic [35:0] d);
    quiet(); ads_ctl_n = 0; addr = a; wr_all_n = gw; din = d;
  endtask

  task automatic t_reset();
    chk("R12 dout_en after reset", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_burst_write_read();
    open_ctl(8'h10, 0, 36'hA0000000A); tick();
    chk("R11 no drive after write", {35'd0, dout_en}, 36'd0);
    quiet(); adv_n = 0; wr_all_n = 0; din = 36'hB0000000B; tick();
    din = 36'hC0000000C; tick();
    din = 36'hD0000000D; tick();
    open_ctl(8'h12, 1, '0); tick();
    chk("R1 read en", {35'd0, dout_en}, 36'd1);
    chk("R1 read data 0x12", dout, 36'hC0000000C);
    quiet(); adv_n = 0; tick();
    chk("R5 advance to 0x13", dout, 36'hD0000000D);
    tick();
    chk("R5 wrap to 0x10", dout, 36'hA0000000A);
    tick();
    chk("R11 advance write 0x11", dout, 36'hB0000000B);
    adv_n = 1; tick();
    chk("R6 hold rereads 0x11", dout, 36'hB0000000B);
    wr_all_n = 0; din = '0; tick();
    chk("R6 hold no write", dout, 36'hB0000000B);
  endtask

  task automatic t_lanes();
    open_ctl(8'h20, 0, 36'hFFFFFFFFF); tick();
    open_ctl(8'h20, 1, '0); wr_byte_n = 0; lane_n = 4'b1010; tick();
    open_ctl(8'h20, 1, '0); wr_byte_n = 1; lane_n = 4'b0000; tick();
    chk("R8 lanes 0,2 written only", dout, 36'hFF803FE00);
    chk("R8 wr_byte_n high reads", {35'd0, dout_en}, 36'd1);
    open_ctl(8'h20, 0, 36'h123456789); wr_byte_n = 1; lane_n = 4'hF; tick();
    open_ctl(8'h20, 1, '0); tick();
    chk("R7 global write all lanes", dout, 36'h123456789);
  endtask

  task automatic t_priority();
    open_ctl(8'h30, 0, 36'h555555555); tick();
    open_ctl(8'h30, 0, 36'h0AAAAAAAA); ads_cpu_n = 0; tick();
    chk("R3 cpu strobe reads", {35'd0, dout_en}, 36'd1);
    chk("R3 cpu strobe old data", dout, 36'h555555555);
    open_ctl(8'h30, 1, '0); tick();
    chk("R3 write enables ignored", dout, 36'h555555555);
  endtask

  task automatic t_gate();
    open_ctl(8'h12, 1, '0); tick();
    quiet(); sel1_n = 1; ads_cpu_n = 0; adv_n = 0; tick();
    chk("R4 cpu strobe ignored, burst advances", dout, 36'hD0000000D);
    chk("R4 still driving", {35'd0, dout_en}, 36'd1);
    quiet(); sel1_n = 1; ads_ctl_n = 0; tick();
    chk("R4 ctl strobe deselects with sel1_n high", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_deselect();
    open_ctl(8'h30, 0, 36'h0DEADBEEF); sel2 = 0; tick();
    chk("R2 deselect quiet", {35'd0, dout_en}, 36'd0);
    open_ctl(8'h30, 1, '0); tick();
    chk("R10 first read masked", {35'd0, dout_en}, 36'd0);
    quiet(); tick();
    chk("R10 drives next clock", {35'd0, dout_en}, 36'd1);
    chk("R2 deselect wrote nothing", dout, 36'h555555555);
  endtask

  task automatic t_oe();
    quiet(); oe_n = 1; #1;
    chk("R9 oe high stops drive", {35'd0, dout_en}, 36'd0);
    oe_n = 0; #1;
    chk("R9 oe low drives", {35'd0, dout_en}, 36'd1);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    quiet();
    tick(); tick();
    t_reset();
    rst_n = 1;
    t_burst_write_read();
    t_lanes();
    t_priority();
    t_gate();
    t_deselect();
    t_oe();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule